// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned words and reports whether the first is greater than, less than or equal to the second. It is built from identical 4-bit slices. Each slice weighs its own pair of nibbles and, only when those nibbles are equal, passes on the verdict that arrives on its cascade inputs from the slice below it. The slices are chained from the least significant nibble upward, so the most significant nibble that differs decides the result. The top module chains `WIDTH/4` slices, where `WIDTH` must be a multiple of the slice width. It also derives greater-or-equal, less-or-equal and not-equal from the three primary flags.

The chain's own cascade inputs are brought out as ports. This lets a wider comparison be built from two or more of these blocks. For a standalone comparison, tie them to greater=0, less=0, equal=1. The block is purely combinational: it has no clock and no reset, and the outputs follow the inputs after the logic delay.

Top module: `mag_cmp_chain`

## Requirements
- R1: `gt_o` is 1 when `a` > `b` (unsigned), or when `a` == `b` and `cin_gt` is 1; otherwise it is 0.
- R2: `lt_o` is 1 when `a` < `b` (unsigned), or when `a` == `b` and `cin_lt` is 1; otherwise it is 0.
- R3: `eq_o` is 1 only when `a` == `b` and `cin_eq` is 1.
- R4: When `a` == `b`, the three cascade inputs pass unchanged to `gt_o`, `lt_o` and `eq_o`. This holds for any input pattern, including ones that are not one-hot.
- R5: When `a` != `b`, the cascade inputs have no effect. `eq_o` is 0, and exactly one of `gt_o` and `lt_o` is 1, chosen by the words alone.
- R6: `ge_o` = `gt_o` | `eq_o`, `le_o` = `lt_o` | `eq_o`, and `ne_o` = !`eq_o`.
- R7: The most significant differing bit decides the result. A difference in a lower slice is overridden by one in a higher slice, for example 0x001F against 0x0020 gives less-than.
- R8: When exactly one cascade input is 1, exactly one of `gt_o`, `lt_o` and `eq_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin_gt | input | 1 | Greater verdict from a less significant stage (tie 0 when standalone) |
| cin_lt | input | 1 | Less verdict from a less significant stage (tie 0 when standalone) |
| cin_eq | input | 1 | Equal verdict from a less significant stage (tie 1 when standalone) |
| gt_o | output | 1 | a greater than b |
| lt_o | output | 1 | a less than b |
| eq_o | output | 1 | a equal to b, qualified by cin_eq |
| ge_o | output | 1 | Greater or equal |
| le_o | output | 1 | Less or equal |
| ne_o | output | 1 | Not equal |

## Verification
The bench targets operands that differ in only one bit, in the top bit or the bottom bit. A slice that scans from the wrong end, or misses the bit-0 term, gives the wrong sign on these. It also uses operands whose lower slice points one way while a higher slice points the other way, such as 0x001F against 0x0020 and 0xFF00 against 0x00FF. A chain linked in the wrong order would report the lower slice's verdict here.

Equal operands are driven with every cascade pattern, including non-one-hot ones. This exposes a slice that ignores its cascade inputs or swaps them. Unequal operands are driven with hostile cascade patterns, which exposes a slice that lets the cascade leak through when its nibbles differ. Random operands and cascades, many of them forced equal, are checked on all six outputs against a reference built from the language's relational operators.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;

  // Width of one comparator slice
  localparam int unsigned SLICE_W = 4;

  // Three-way verdict carried between slices
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } rel_t;

  // Verdict a standalone chain starts from: "equal so far"
  localparam rel_t REL_SEED = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};

endpackage

// File: rtl/mcmp_bit_scan.sv
// Local unsigned compare of two words, scanning from the MSB downward.
// An equality carry starts at 1 above the MSB and survives only while bit
// pairs match; the first mismatching pair decides greater or less.
module mcmp_bit_scan #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_gt,
  output logic         a_lt,
  output logic         a_eq
);

  logic [W:0]   same_above;
  logic [W-1:0] differ;
  logic [W-1:0] win_gt;
  logic [W-1:0] win_lt;

  assign same_above[W] = 1'b1;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    assign differ[i]     = (a[i] & ~b[i]) | (~a[i] & b[i]);
    assign same_above[i] = same_above[i+1] & ~differ[i];
    assign win_gt[i]     = same_above[i+1] & a[i] & ~b[i];
    assign win_lt[i]     = same_above[i+1] & ~a[i] & b[i];
  end

  assign a_gt = |win_gt;
  assign a_lt = |win_lt;
  assign a_eq = same_above[0];

endmodule

// File: rtl/mcmp_cascade_merge.sv
// Combines a slice's local verdict with the verdict arriving from below.
module mcmp_cascade_merge
  import mcmp_pkg::*;
(
  input  logic local_gt,
  input  logic local_lt,
  input  logic local_eq,
  input  rel_t from_below,
  output rel_t merged
);

  always_comb begin
    merged.gt = local_gt | (local_eq & from_below.gt);
    merged.lt = local_lt | (local_eq & from_below.lt);
    merged.eq = local_eq & from_below.eq;
  end

endmodule

// File: rtl/mcmp_slice.sv
// One cascadable comparator slice.
module mcmp_slice
  import mcmp_pkg::*;
#(
  parameter int unsigned SW = SLICE_W
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  rel_t          casc_in,
  output rel_t          casc_out
);

  logic loc_gt;
  logic loc_lt;
  logic loc_eq;

  mcmp_bit_scan #(.W(SW)) u_scan (
    .a    (a),
    .b    (b),
    .a_gt (loc_gt),
    .a_lt (loc_lt),
    .a_eq (loc_eq)
  );

  mcmp_cascade_merge u_merge (
    .local_gt   (loc_gt),
    .local_lt   (loc_lt),
    .local_eq   (loc_eq),
    .from_below (casc_in),
    .merged     (casc_out)
  );

endmodule

// File: rtl/mcmp_derive.sv
// Secondary relations built from the final three-way verdict.
module mcmp_derive
  import mcmp_pkg::*;
(
  input  rel_t verdict,
  output logic ge,
  output logic le,
  output logic ne
);

  assign ge = verdict.gt | verdict.eq;
  assign le = verdict.lt | verdict.eq;
  assign ne = ~verdict.eq;

endmodule

// File: rtl/mag_cmp_chain.sv
// Wide unsigned magnitude comparator: slice 0 holds the least significant
// nibble and each slice feeds the next more significant one.
module mag_cmp_chain
  import mcmp_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned SLICE_B = SLICE_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin_gt,
  input  logic             cin_lt,
  input  logic             cin_eq,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o,
  output logic             ge_o,
  output logic             le_o,
  output logic             ne_o
);

  localparam int unsigned NSLICE = WIDTH / SLICE_B;

  if (NSLICE * SLICE_B != WIDTH || NSLICE == 0) begin : g_bad_width
    $error("WIDTH must be a non-zero multiple of the slice width");
  end

  rel_t link [NSLICE+1];

  assign link[0] = '{gt: cin_gt, lt: cin_lt, eq: cin_eq};

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    mcmp_slice #(.SW(SLICE_B)) u_slice (
      .a        (a[k*SLICE_B +: SLICE_B]),
      .b        (b[k*SLICE_B +: SLICE_B]),
      .casc_in  (link[k]),
      .casc_out (link[k+1])
    );
  end

  assign gt_o = link[NSLICE].gt;
  assign lt_o = link[NSLICE].lt;
  assign eq_o = link[NSLICE].eq;

  mcmp_derive u_derive (
    .verdict (link[NSLICE]),
    .ge      (ge_o),
    .le      (le_o),
    .ne      (ne_o)
  );

endmodule

// File: rtl/mag_cmp_chain_chk.sv
// Checker relating the ports of mag_cmp_chain to a word-level reference.
module mag_cmp_chain_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin_gt,
  input logic             cin_lt,
  input logic             cin_eq,
  input logic             gt_o,
  input logic             lt_o,
  input logic             eq_o,
  input logic             ge_o,
  input logic             le_o,
  input logic             ne_o
);

  always_comb begin
    assert_gt_R1: assert (gt_o == ((a > b) || ((a == b) && cin_gt)))
      else $error("gt_o disagrees with operands");
    assert_lt_R2: assert (lt_o == ((a < b) || ((a == b) && cin_lt)))
      else $error("lt_o disagrees with operands");
    assert_eq_R3: assert (eq_o == ((a == b) && cin_eq))
      else $error("eq_o disagrees with operands");
    if (a == b) begin
      assert_pass_R4: assert ({gt_o, lt_o, eq_o} == {cin_gt, cin_lt, cin_eq})
        else $error("cascade not passed through on equal words");
    end
    if (a != b) begin
      assert_ignore_R5: assert (!eq_o && $countones({gt_o, lt_o}) == 1)
        else $error("cascade leaked on unequal words");
    end
    assert_ge_R6: assert (ge_o == ((a > b) || ((a == b) && (cin_gt || cin_eq))))
      else $error("ge_o wrong");
    assert_le_R6: assert (le_o == ((a < b) || ((a == b) && (cin_lt || cin_eq))))
      else $error("le_o wrong");
    assert_ne_R6: assert (ne_o == ((a != b) || !cin_eq))
      else $error("ne_o wrong");
    if ($countones({cin_gt, cin_lt, cin_eq}) == 1) begin
      assert_onehot_R8: assert ($countones({gt_o, lt_o, eq_o}) == 1)
        else $error("verdict not one-hot");
    end
  end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/mag_cmp_chain_tb.sv
module mag_cmp_chain_tb;

  localparam int unsigned WIDTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [WIDTH-1:0] a, b;
  logic cin_gt, cin_lt, cin_eq;
  logic gt_o, lt_o, eq_o, ge_o, le_o, ne_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  mag_cmp_chain #(.WIDTH(WIDTH)) u_dut (
    .a(a), .b(b), .cin_gt(cin_gt), .cin_lt(cin_lt), .cin_eq(cin_eq),
    .gt_o(gt_o), .lt_o(lt_o), .eq_o(eq_o),
    .ge_o(ge_o), .le_o(le_o), .ne_o(ne_o)
  );

  // Reference: {gt, lt, eq, ge, le, ne}
  function automatic logic [5:0] ref_flags(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y,
                                           logic cg, logic cl, logic ce);
    logic g, l, e;
    g = (x > y) || ((x == y) && cg);
    l = (x < y) || ((x == y) && cl);
    e = (x == y) && ce;
    return {g, l, e, g | e, l | e, ~e};
  endfunction

  task automatic apply(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y,
                       logic cg, logic cl, logic ce, string req);
    logic [5:0] exp, got;
    @(negedge clk);
    a = x; b = y; cin_gt = cg; cin_lt = cl; cin_eq = ce;
    #5;
    exp = ref_flags(x, y, cg, cl, ce);
    got = {gt_o, lt_o, eq_o, ge_o, le_o, ne_o};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h casc=%b%b%b got=%b exp=%b",
               req, x, y, cg, cl, ce, got, exp);
    end
    if ($countones({cg, cl, ce}) == 1) begin
      total++;
      if ($countones({gt_o, lt_o, eq_o}) != 1) begin
        bad++;
        $display("FAIL R8 a=%h b=%h got=%b exp=one-hot", x, y, {gt_o, lt_o, eq_o});
      end
    end
  endtask

  initial begin
    a = '0; b = '0; cin_gt = 1'b0; cin_lt = 1'b0; cin_eq = 1'b1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state: zero operands with standalone cascade read as equal
    apply('0, '0, 1'b0, 1'b0, 1'b1, "R3 R6 idle");
    // Plain relations
    apply(16'h1234, 16'h1233, 1'b0, 1'b0, 1'b1, "R1");
    apply(16'h0001, 16'h0000, 1'b0, 1'b0, 1'b1, "R1 lsb");
    apply(16'h8000, 16'h7FFF, 1'b0, 1'b0, 1'b1, "R1 msb");
    apply(16'h7FFF, 16'h8000, 1'b0, 1'b0, 1'b1, "R2 msb");
    apply(16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R2");
    apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, "R3 max");
    // Higher slice overrides lower one
    apply(16'h001F, 16'h0020, 1'b0, 1'b0, 1'b1, "R7 lt");
    apply(16'hFF00, 16'h00FF, 1'b0, 1'b0, 1'b1, "R7 gt");
    apply(16'h1F00, 16'h2000, 1'b0, 1'b0, 1'b1, "R7 mid");
    // Cascade passes through on equal words, all eight patterns
    for (int p = 0; p < 8; p++)
      apply(16'hA5C3, 16'hA5C3, p[2], p[1], p[0], "R4");
    // Cascade ignored on unequal words
    for (int p = 0; p < 8; p++) begin
      apply(16'h4000, 16'h3FFF, p[2], p[1], p[0], "R5 gt");
      apply(16'h0000, 16'h0001, p[2], p[1], p[0], "R5 lt");
    end
    // Derived flags on each one-hot cascade
    apply(16'h5555, 16'h5555, 1'b1, 1'b0, 1'b0, "R6 R8");
    apply(16'h5555, 16'h5555, 1'b0, 1'b1, 1'b0, "R6 R8");
    // Random operands and cascades
    void'($urandom(32'h00C0FFEE));
    for (int n = 0; n < 3000; n++) begin
      logic [WIDTH-1:0] x, y;
      logic [2:0] c;
      x = WIDTH'($urandom);
      y = ($urandom_range(3) == 0) ? x : WIDTH'($urandom);
      if ($urandom_range(4) == 0) y = x ^ (WIDTH'(1) << $urandom_range(WIDTH - 1));
      c = ($urandom_range(1) == 0) ? 3'b001 : 3'($urandom);
      apply(x, y, c[2], c[1], c[0], (x == y) ? "R3 R4 R6" : "R1 R2 R5 R6");
    end
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule